// File: doc/BRIEF.md
# Multi-Channel Prescaled Reload Timer

A peripheral holding two or three identical down-counting timer channels. A simple memory-mapped bus reaches them: byte address, write data, write strobe, read strobe, and a combinational read-data path. A single run register starts and stops each channel on its own. Every channel owns three registers. A reload register holds the period. A count register shows the live value and can be loaded. A mode register picks a tick rate from the input clock by a power-of-four divider, keeps the underflow flag, and gates that flag onto the channel's interrupt line.

A running channel counts down once per divided tick. When it steps down from zero, it refills from its reload register and raises its underflow flag. Software can only clear the flag, by writing the mode register with the flag bit low. Each write to the mode register also refills the counter and restarts the divider.

A build-time switch decides whether the third channel exists. Illegal settings, unmapped or misaligned accesses, and run requests for a channel that is absent all raise a one-cycle error pulse. In each of these cases the offending write is thrown away.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset, every reload and count register reads 0xFFFFFFFF. Every mode register and the run register read 0. Both `irq` and `err` are low.
- R2: The run register sits at byte 0x04 and is 3 bits wide, with upper bits reading 0. Bit n runs channel n. A read returns the last accepted write.
- R3: Channel n starts at byte 0x08 + 12·n. The reload register is at +0, the count register at +4 and the mode register at +8. Reload and count registers are written and read as full 32-bit words, and each channel's registers are independent of the others.
- R4: Mode bits [2:0] pick the tick divider: 0→4, 1→16, 2→64, 3→256, 4→1024 input clocks. After the mode write and then the run-bit write, a running channel's count drops by one every divider period. The first drop comes one full period after the run-bit write.
- R5: A tick that finds the count at zero reloads the count from the reload register and sets the underflow flag, mode bit 8.
- R6: `irq[n]` is high exactly when channel n's underflow flag and its interrupt enable (mode bit 5) are both 1.
- R7: A mode write with bit 8 at 0 clears the underflow flag. A mode write with bit 8 at 1 leaves the flag as it was. No write ever sets the flag.
- R8: Every accepted mode write loads the count from the reload register and restarts the divider from zero.
- R9: A mode write with divider code 5, 6 or 7, or with any bit set outside bits 0–2, 5, 8 and 9, raises `err` in the next cycle and changes nothing. Bit 9 is accepted, always stored as 0 and always read as 0.
- R10: A read or write to an address that maps no register raises `err` in the next cycle. Such addresses include 0x00, misaligned offsets and anything past the last channel. The write changes nothing.
- R11: When the third channel is not built, a run-register write with bit 2 set raises `err`, and the whole write is discarded. Any access at 0x20 or above also raises `err`.
- R12: A channel whose run bit is 0 holds its count and its divider phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the divider source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write strobe, one access per cycle |
| re | input | 1 | Read strobe, used only for error detection |
| rdata | output | DATA_W | Combinational read data for `addr` |
| err | output | 1 | One-cycle pulse after an illegal access |
| irq | output | NCH | Per-channel interrupt, underflow flag AND enable |

## Verification
A register write sampled at a clock edge is visible on `rdata`, and its `err` pulse on the output, from that same edge onward. The bench drives on falling edges and samples half a cycle later. After a run-bit write at edge S, the k-th count drop lands at edge S + k·D. The bench counts falling edges from that write and computes the expected count and underflow flag from that number. Reads are combinational and are taken 1 ns after a falling edge, so they never straddle a rising edge and never move the timing.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int PS_W      = 3;
  localparam int PS_MAX    = 4;
  localparam int PRE_W     = 10;
  localparam int START_W   = 3;
  localparam int START_OFS = 4;
  localparam int CH_BASE   = 8;
  localparam int CH_STRIDE = 12;
  localparam int IE_BIT    = 5;
  localparam int UF_BIT    = 8;
  localparam int CAP_BIT   = 9;

  localparam logic [1:0] W_RELOAD = 2'd0;
  localparam logic [1:0] W_COUNT  = 2'd1;
  localparam logic [1:0] W_MODE   = 2'd2;

  // terminal value of the per-channel divider for a legal code
  function automatic logic [PRE_W-1:0] div_last(input logic [PS_W-1:0] ps);
    logic [PRE_W:0] full;
    full = (PRE_W+1)'(1) << (2 * int'(ps) + 2);
    if (ps > PS_W'(PS_MAX)) return '0;
    return PRE_W'(full - 1'b1);
  endfunction
endpackage

// File: rtl/prt_rst_sync.sv
module prt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
  parameter int PRE_W = prt_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PRE_W-1:0] last,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d;

  assign tick = en && !clr && (pre_q == last);

  always_comb begin
    pre_d = pre_q;
    if (clr || tick) pre_d = '0;
    else if (en)     pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/prt_channel.sv
module prt_channel
  import prt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_reload,
  input  logic              wr_count,
  input  logic              wr_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reload_q,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] mode_rd,
  output logic              irq
);
  logic [DATA_W-1:0] reload_d, count_d;
  logic [PS_W-1:0]   ps_q, ps_d;
  logic              ie_q, ie_d, uf_q, uf_d;
  logic [PRE_W-1:0]  pre_last;
  logic              tick;

  assign pre_last = div_last(ps_q);

  prt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (wr_mode),
    .en   (run),
    .last (pre_last),
    .tick (tick)
  );

  always_comb begin
    reload_d = wr_reload ? wdata : reload_q;
    count_d  = count_q;
    ps_d     = ps_q;
    ie_d     = ie_q;
    uf_d     = uf_q;
    if (wr_mode) begin
      ps_d    = wdata[PS_W-1:0];
      ie_d    = wdata[IE_BIT];
      count_d = reload_q;
      if (!wdata[UF_BIT]) uf_d = 1'b0;
    end else if (wr_count) begin
      count_d = wdata;
    end else if (tick) begin
      if (count_q == '0) begin
        count_d = reload_q;
        uf_d    = 1'b1;
      end else begin
        count_d = count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      count_q  <= '1;
      ps_q     <= '0;
      ie_q     <= 1'b0;
      uf_q     <= 1'b0;
    end else begin
      reload_q <= reload_d;
      count_q  <= count_d;
      ps_q     <= ps_d;
      ie_q     <= ie_d;
      uf_q     <= uf_d;
    end
  end

  always_comb begin
    mode_rd             = '0;
    mode_rd[PS_W-1:0]   = ps_q;
    mode_rd[IE_BIT]     = ie_q;
    mode_rd[UF_BIT]     = uf_q;
  end

  assign irq = uf_q & ie_q;
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
  import prt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter bit HAS_CH2 = 1'b1,
  localparam int NCH    = HAS_CH2 ? 3 : 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic [NCH-1:0]    irq
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    DATA_W'((1 << IE_BIT) | (1 << UF_BIT) | (1 << CAP_BIT) | ((1 << PS_W) - 1));
  localparam logic [DATA_W-1:0] RSV_MASK = ~KEEP_MASK;
  localparam bit NO_CH2 = !HAS_CH2;

  logic                          rst_int_n;
  logic [START_W-1:0]            start_q, start_d;
  logic                          err_d;
  logic                          start_hit, start_bad, mode_bad, any_mode_hit;
  logic                          hit_any, wr_bad, wr_ok;
  logic [NCH-1:0]                hit_ch, mode_hit;
  logic [NCH-1:0][1:0]           ch_word;
  logic [NCH-1:0][DATA_W-1:0]    ch_reload, ch_count, ch_mode;

  prt_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_int_n)
  );

  // address decode, one window per channel
  for (genvar i = 0; i < NCH; i++) begin : g_dec
    localparam int BASE = CH_BASE + CH_STRIDE * i;
    logic [ADDR_W-1:0] rel;
    assign rel         = addr - ADDR_W'(BASE);
    assign hit_ch[i]   = (addr >= ADDR_W'(BASE)) && (rel < ADDR_W'(CH_STRIDE)) &&
                         (rel[1:0] == 2'b00);
    assign ch_word[i]  = rel[3:2];
    assign mode_hit[i] = hit_ch[i] && (ch_word[i] == W_MODE);
  end

  assign start_hit    = (addr == ADDR_W'(START_OFS));
  assign hit_any      = start_hit || (|hit_ch);
  assign any_mode_hit = |mode_hit;
  assign mode_bad     = (wdata[PS_W-1:0] > PS_W'(PS_MAX)) || (|(wdata & RSV_MASK));
  assign start_bad    = start_hit && NO_CH2 && wdata[START_W-1];
  assign wr_bad       = we && (!hit_any || start_bad || (any_mode_hit && mode_bad));
  assign wr_ok        = we && !wr_bad;
  assign err_d        = wr_bad || (re && !hit_any);

  always_comb begin
    start_d = start_q;
    if (wr_ok && start_hit) start_d = wdata[START_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      start_q <= '0;
      err     <= 1'b0;
    end else begin
      start_q <= start_d;
      err     <= err_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    prt_channel #(.DATA_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .run      (start_q[i]),
      .wr_reload(wr_ok && hit_ch[i] && (ch_word[i] == W_RELOAD)),
      .wr_count (wr_ok && hit_ch[i] && (ch_word[i] == W_COUNT)),
      .wr_mode  (wr_ok && mode_hit[i]),
      .wdata    (wdata),
      .reload_q (ch_reload[i]),
      .count_q  (ch_count[i]),
      .mode_rd  (ch_mode[i]),
      .irq      (irq[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (start_hit) rdata[START_W-1:0] = start_q;
    for (int i = 0; i < NCH; i++) begin
      if (hit_ch[i]) begin
        case (ch_word[i])
          W_RELOAD: rdata = ch_reload[i];
          W_COUNT:  rdata = ch_count[i];
          W_MODE:   rdata = ch_mode[i];
          default:  rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/prt_checker.sv
module prt_checker
  import prt_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          addr,
  input logic                       we,
  input logic                       re,
  input logic                       err,
  input logic [START_W-1:0]         start_q,
  input logic [NCH-1:0][DATA_W-1:0] ch_const,
  input logic [NCH-1:0][DATA_W-1:0] ch_count,
  input logic [NCH-1:0][DATA_W-1:0] ch_ctrl
);
  localparam logic [DATA_W-1:0] UF_MASK = DATA_W'(1 << UF_BIT);

  // R10: an error pulse always follows an access
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(we || re));

  if (NCH < START_W) begin : g_two
    // R11: the missing channel can never be started
    p_no_ch2_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !start_q[START_W-1]);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] MADDR = ADDR_W'(CH_BASE + CH_STRIDE * i + 8);

    // R5: the flag rises only on a running tick from zero
    p_uf_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_ctrl[i][UF_BIT]) |-> ($past(ch_count[i]) == '0) && $past(start_q[i]));

    // R5: the refill value is the reload register
    p_uf_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_ctrl[i][UF_BIT]) |-> ch_count[i] == $past(ch_const[i]));

    // R7: with the channel stopped nothing can set the flag
    p_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start_q[i]) |-> !$rose(ch_ctrl[i][UF_BIT]));

    // R8: an accepted mode write refills the count
    p_mode_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(we) && ($past(addr) == MADDR) && !err) |-> ch_count[i] == $past(ch_const[i]));

    // R9: a rejected write leaves the mode settings alone
    p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err && $past(we)) |-> (ch_ctrl[i] & ~UF_MASK) == ($past(ch_ctrl[i]) & ~UF_MASK));

    // R12: a stopped channel without bus writes holds its count
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start_q[i]) && !$past(we)) |-> $stable(ch_count[i]));
  end
endmodule

bind prescaled_reload_timer prt_checker #(
  .NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .addr    (addr),
  .we      (we),
  .re      (re),
  .err     (err),
  .start_q (start_q),
  .ch_const(ch_reload),
  .ch_count(ch_count),
  .ch_ctrl (ch_mode)
);

// File: tb/prescaled_reload_timer_tb.sv
module prescaled_reload_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we0 = 1'b0, re0 = 1'b0, we1 = 1'b0, re1 = 1'b0;
  logic [31:0] rdata0, rdata1;
  logic        err0, err1;
  logic [2:0]  irq0;
  logic [1:0]  irq1;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  prescaled_reload_timer #(.HAS_CH2(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we0), .re(re0),
    .rdata(rdata0), .err(err0), .irq(irq0));

  prescaled_reload_timer #(.HAS_CH2(1'b0)) u_dut_two (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we1), .re(re1),
    .rdata(rdata1), .err(err1), .irq(irq1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int d, input logic [7:0] a, input logic [31:0] dat);
    @(negedge clk);
    addr = a; wdata = dat;
    if (d == 0) we0 = 1'b1; else we1 = 1'b1;
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0;
  endtask

  task automatic rd(input int d, input logic [7:0] a, output logic [31:0] dat);
    addr = a;
    #1;
    dat = (d == 0) ? rdata0 : rdata1;
  endtask

  task automatic rd_strobe(input int d, input logic [7:0] a);
    @(negedge clk);
    addr = a;
    if (d == 0) re0 = 1'b1; else re1 = 1'b1;
    @(negedge clk);
    re0 = 1'b0; re1 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int div_of(input int ps);
    return 4 << (2 * ps);
  endfunction

  function automatic logic [31:0] exp_cnt(input int c, input int m, input int d);
    int t = m / d;
    return 32'(c - (t % (c + 1)));
  endfunction

  function automatic logic exp_uf(input int c, input int m, input int d);
    return (m / d) >= (c + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int c = 0; c < 3; c++) begin
      rd(0, 8'(8 + 12 * c), v);     chk("R1 reload", v, 32'hFFFF_FFFF);
      rd(0, 8'(8 + 12 * c + 4), v); chk("R1 count", v, 32'hFFFF_FFFF);
      rd(0, 8'(8 + 12 * c + 8), v); chk("R1 mode", v, 32'h0);
      idle(1);
    end
    rd(0, 8'h04, v); chk("R1 run", v, 32'h0);
    chk("R1 irq", {29'd0, irq0}, 32'h0);
    chk("R1 err", {31'd0, err0}, 32'h0);

    // R3 register map and independence
    wr(0, 8'h20, 32'h0000_1234);
    wr(0, 8'h18, 32'h0000_ABCD);
    rd(0, 8'h20, v); chk("R3 ch2 reload", v, 32'h0000_1234);
    rd(0, 8'h18, v); chk("R3 ch1 count", v, 32'h0000_ABCD);
    rd(0, 8'h0C, v); chk("R3 ch0 count untouched", v, 32'hFFFF_FFFF);

    // R2 run register readback
    wr(0, 8'h04, 32'hFFFF_FFF8);
    rd(0, 8'h04, v); chk("R2 upper bits", v, 32'h0);
    wr(0, 8'h04, 32'h5);
    rd(0, 8'h04, v); chk("R2 readback", v, 32'h5);
    wr(0, 8'h04, 32'h0);

    // R4 every divider code on channel 2
    for (int p = 0; p <= 4; p++) begin
      wr(0, 8'h20, 32'd3);
      wr(0, 8'h28, 32'(p));
      wr(0, 8'h04, 32'h4);
      idle(div_of(p) - 1);
      rd(0, 8'h24, v); chk($sformatf("R4 code %0d before tick", p), v, 32'd3);
      idle(1);
      rd(0, 8'h24, v); chk($sformatf("R4 code %0d first tick", p), v, 32'd2);
      wr(0, 8'h04, 32'h0);
    end

    // R5 / R6 underflow and interrupt on channel 0
    wr(0, 8'h08, 32'd2);
    wr(0, 8'h10, 32'h20);
    wr(0, 8'h04, 32'h1);
    idle(11);
    rd(0, 8'h0C, v); chk("R5 count at zero", v, 32'd0);
    chk("R6 irq low before underflow", {31'd0, irq0[0]}, 32'd0);
    idle(1);
    rd(0, 8'h0C, v); chk("R5 refill", v, 32'd2);
    rd(0, 8'h10, v); chk("R5 flag set", v, 32'h120);
    chk("R6 irq high", {31'd0, irq0[0]}, 32'd1);
    wr(0, 8'h04, 32'h0);

    // R7 flag write rules
    wr(0, 8'h10, 32'h120);
    rd(0, 8'h10, v); chk("R7 write one keeps flag", v, 32'h120);
    chk("R6 irq still high", {31'd0, irq0[0]}, 32'd1);
    wr(0, 8'h10, 32'h020);
    rd(0, 8'h10, v); chk("R7 write zero clears", v, 32'h020);
    chk("R6 irq cleared", {31'd0, irq0[0]}, 32'd0);
    wr(0, 8'h10, 32'h120);
    rd(0, 8'h10, v); chk("R7 write cannot set", v, 32'h020);

    // R8 mode write refills the count
    wr(0, 8'h0C, 32'd7);
    rd(0, 8'h0C, v); chk("R8 count loaded", v, 32'd7);
    wr(0, 8'h10, 32'h0);
    rd(0, 8'h0C, v); chk("R8 refill on mode write", v, 32'd2);

    // R12 stopped channel holds
    idle(20);
    rd(0, 8'h0C, v); chk("R12 hold", v, 32'd2);

    // R9 illegal mode settings
    wr(0, 8'h1C, 32'h21);
    chk("R9 legal no err", {31'd0, err0}, 32'd0);
    wr(0, 8'h1C, 32'h05);
    chk("R9 code 5 err", {31'd0, err0}, 32'd1);
    rd(0, 8'h1C, v); chk("R9 code 5 discarded", v, 32'h21);
    idle(1);
    chk("R9 err one cycle", {31'd0, err0}, 32'd0);
    wr(0, 8'h1C, 32'h07);
    chk("R9 code 7 err", {31'd0, err0}, 32'd1);
    wr(0, 8'h1C, 32'h1001);
    chk("R9 reserved bit err", {31'd0, err0}, 32'd1);
    rd(0, 8'h1C, v); chk("R9 reserved discarded", v, 32'h21);
    wr(0, 8'h1C, 32'h222);
    chk("R9 bit 9 accepted", {31'd0, err0}, 32'd0);
    rd(0, 8'h1C, v); chk("R9 bit 9 reads zero", v, 32'h22);

    // R10 unmapped accesses
    wr(0, 8'h00, 32'h1);
    chk("R10 write 0x00 err", {31'd0, err0}, 32'd1);
    wr(0, 8'h09, 32'h55);
    chk("R10 misaligned err", {31'd0, err0}, 32'd1);
    rd(0, 8'h08, v); chk("R10 misaligned no effect", v, 32'd2);
    rd_strobe(0, 8'h2C);
    chk("R10 read past end err", {31'd0, err0}, 32'd1);
    rd_strobe(0, 8'h14);
    chk("R10 mapped read no err", {31'd0, err0}, 32'd0);

    // R11 build without the third channel
    wr(1, 8'h04, 32'h4);
    chk("R11 run bit 2 err", {31'd0, err1}, 32'd1);
    rd(1, 8'h04, v); chk("R11 run write discarded", v, 32'h0);
    wr(1, 8'h04, 32'h3);
    chk("R11 two channels no err", {31'd0, err1}, 32'd0);
    rd(1, 8'h04, v); chk("R11 run readback", v, 32'h3);
    wr(1, 8'h20, 32'h1);
    chk("R11 access 0x20 err", {31'd0, err1}, 32'd1);
    wr(1, 8'h04, 32'h0);

    // R4 / R5 / R6 random runs on channels 0 and 1
    for (int it = 0; it < 40; it++) begin
      int ch  = int'($urandom % 2);
      int c   = int'($urandom % 6);
      int ps  = int'($urandom % 2);
      int ie  = int'($urandom % 2);
      int m   = int'($urandom % 60);
      int d   = div_of(ps);
      logic uf;
      wr(0, 8'h04, 32'h0);
      wr(0, 8'(8 + 12 * ch), 32'(c));
      wr(0, 8'(8 + 12 * ch + 8), 32'(ps | (ie << 5)));
      wr(0, 8'h04, 32'(1 << ch));
      idle(m);
      uf = exp_uf(c, m, d);
      rd(0, 8'(8 + 12 * ch + 4), v);
      chk($sformatf("R4 random count ch%0d m=%0d", ch, m), v, exp_cnt(c, m, d));
      rd(0, 8'(8 + 12 * ch + 8), v);
      chk("R5 random mode", v, 32'(ps | (ie << 5) | (int'(uf) << 8)));
      chk("R6 random irq", {31'd0, irq0[ch]}, {31'd0, uf & ie[0]});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule